// File: doc/BRIEF.md
# Transmit VLAN Tag Insertion and Short-Frame Padding Stage

This stage sits on the transmit byte stream in front of the CRC generator. Frame bytes come in one per transfer on a valid/ready interface, with a start marker on the first byte and an end marker on the last. A per-frame request bit travels with the first byte. When that bit or a global enable is set, the stage places a 4-byte VLAN tag right after the two 6-byte address fields, at byte offset 12. The tag value comes from a configuration input, and its most significant byte is sent first.

After any insertion, a frame that is still shorter than 60 bytes is extended with zero bytes. The later 4-byte CRC then brings it to the 64-byte Ethernet minimum. The end marker moves to the last pad byte. A frame that requests a tag but ends before byte 12 has no place for one. It is sent untagged, padded, and flagged with a one-cycle error pulse.

The output is registered, so the latency is one cycle. Backpressure from the output freezes every piece of internal state. While tag bytes or pad bytes are being emitted, the input is held off.

Top module: `tx_tag_pad`

## Requirements
- R1: Without insertion, every input byte appears on the output unchanged and in order. Start is marked on the first output byte of a frame, and end on the last input byte when the frame is 60 bytes or longer.
- R2: A frame whose length after any insertion is below 60 bytes is followed by zero-valued bytes until it is exactly 60 bytes long. The end marker sits on the last pad byte only.
- R3: With insertion, output bytes 12 to 15 carry the 32-bit tag register value, bits 31:24 first and bits 7:0 last. Input byte 12 onward follows the tag.
- R4: Insertion happens when the global enable is set or the request bit sampled with the start byte is set. The pad decision uses the tagged length, so a tagged frame of 56 or more input bytes gets no pad.
- R5: While the four tag bytes are emitted, the input is not accepted. With no output backpressure, a long tagged frame sees exactly 4 stall cycles.
- R6: While the output holds valid data and ready is low, the output data and markers stay unchanged. No byte is lost or repeated under any backpressure pattern.
- R7: A frame of fewer than 12 bytes with insertion requested is sent untagged and padded, and the error output is high for exactly one cycle per such frame.
- R8: After reset, the output is not valid, the error output is low, and the input is ready.
- R9: A frame of exactly 12 bytes with insertion requested gets the tag appended after its last byte, followed by pad bytes up to 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tag_all | input | 1 | Global insertion enable, sampled at frame start |
| cfg_tag | input | 32 | Tag value, most significant byte sent first |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_tag_req | input | 1 | Per-frame insertion request, sampled with the first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of frame |
| out_eof | output | 1 | Last output byte of frame |
| err_short | output | 1 | One-cycle pulse for a tag request on a frame too short to hold a tag |

## Verification
The bench aims at the length boundaries around the pad threshold: 55, 56, 59, 60 and 61 bytes, tagged and untagged. A stage that decides padding on the pre-tag length emits four stray zero bytes, and an off-by-one moves the end marker. The 11-, 12- and 13-byte tagged frames probe where the tag lands. A wrong offset compare either drops the tag or errors on a 12-byte frame. Random output backpressure and bursty input check that stalls neither drop nor repeat a byte. A directed long frame counts the input stall cycles, which exposes a tag sequencer that runs short or long.

// File: rtl/tx_tag_pad_pkg.sv
package tx_tag_pad_pkg;

    // Byte source selected for the output register.
    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_TAG  = 2'd1,
        ST_PAD  = 2'd2
    } src_state_e;

endpackage

// File: rtl/tx_tag_pad_tagsel.sv
module tx_tag_pad_tagsel #(
    parameter int TAG_BYTES = 4,
    localparam int IW = (TAG_BYTES > 1) ? $clog2(TAG_BYTES) : 1
) (
    input  logic [8*TAG_BYTES-1:0] tag_word,
    input  logic [IW-1:0]          idx,
    output logic [7:0]             tag_byte
);

    logic [7:0] lanes [TAG_BYTES];

    // Lane 0 is the most significant byte of the tag word.
    for (genvar g = 0; g < TAG_BYTES; g++) begin : g_lane
        assign lanes[g] = tag_word[8*(TAG_BYTES-1-g) +: 8];
    end

    assign tag_byte = lanes[idx];

endmodule

// File: rtl/tx_tag_pad_ctrl.sv
module tx_tag_pad_ctrl
    import tx_tag_pad_pkg::*;
#(
    parameter int TAG_BYTES = 4,
    parameter int ADDR_LEN  = 12,
    parameter int MIN_LEN   = 60,
    localparam int IW = (TAG_BYTES > 1) ? $clog2(TAG_BYTES) : 1,
    localparam int CW = $clog2(MIN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_tag_all,
    input  logic [7:0]    tag_byte,
    output logic [IW-1:0] tag_idx,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic          in_tag_req,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_sof,
    output logic          out_eof,
    output logic          err_short
);

    localparam logic [CW-1:0] ADDR_C = CW'(ADDR_LEN);
    localparam logic [CW-1:0] MIN_C  = CW'(MIN_LEN);
    localparam logic [IW-1:0] LAST_T = IW'(TAG_BYTES - 1);

    typedef struct packed {
        src_state_e    st;
        logic [CW-1:0] cnt;       // bytes emitted in this frame, saturating
        logic [IW-1:0] tidx;      // next tag byte index
        logic          ins;       // insertion still pending for this frame
        logic          eof_seen;  // last input byte already taken before tag
        logic          ov;
        logic [7:0]    od;
        logic          osof;
        logic          oeof;
        logic          err;
    } ctrl_t;

    ctrl_t q, d;

    logic          adv;
    logic [CW-1:0] base_c;
    logic [CW-1:0] nxt_c;
    logic          ins_now;

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
        return (c >= MIN_C) ? MIN_C : c + 1'b1;
    endfunction

    assign adv      = !q.ov || out_ready;
    assign in_ready = adv && (q.st == ST_PASS);

    always_comb begin
        d       = q;
        d.err   = 1'b0;
        base_c  = '0;
        nxt_c   = '0;
        ins_now = 1'b0;
        if (adv) begin
            d.ov = 1'b0;
            unique case (q.st)
                ST_PASS: begin
                    if (in_valid) begin
                        base_c  = in_sof ? '0 : q.cnt;
                        ins_now = in_sof ? (cfg_tag_all | in_tag_req) : q.ins;
                        nxt_c   = bump(base_c);
                        d.ov    = 1'b1;
                        d.od    = in_data;
                        d.osof  = in_sof;
                        d.oeof  = 1'b0;
                        d.cnt   = nxt_c;
                        d.ins   = ins_now;
                        if (ins_now && (nxt_c == ADDR_C)) begin
                            d.st       = ST_TAG;
                            d.tidx     = '0;
                            d.eof_seen = in_eof;
                            d.ins      = 1'b0;
                        end else if (in_eof) begin
                            d.err = ins_now;
                            d.ins = 1'b0;
                            if (nxt_c < MIN_C) begin
                                d.st = ST_PAD;
                            end else begin
                                d.oeof = 1'b1;
                            end
                        end
                    end
                end
                ST_TAG: begin
                    nxt_c  = bump(q.cnt);
                    d.ov   = 1'b1;
                    d.od   = tag_byte;
                    d.osof = 1'b0;
                    d.oeof = 1'b0;
                    d.cnt  = nxt_c;
                    d.tidx = q.tidx + 1'b1;
                    if (q.tidx == LAST_T) begin
                        if (!q.eof_seen) begin
                            d.st = ST_PASS;
                        end else if (nxt_c < MIN_C) begin
                            d.st = ST_PAD;
                        end else begin
                            d.st   = ST_PASS;
                            d.oeof = 1'b1;
                        end
                    end
                end
                ST_PAD: begin
                    nxt_c  = bump(q.cnt);
                    d.ov   = 1'b1;
                    d.od   = 8'h00;
                    d.osof = 1'b0;
                    d.oeof = 1'b0;
                    d.cnt  = nxt_c;
                    if (nxt_c >= MIN_C) begin
                        d.oeof = 1'b1;
                        d.st   = ST_PASS;
                    end
                end
                default: d.st = ST_PASS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tag_idx   = q.tidx;
    assign out_valid = q.ov;
    assign out_data  = q.od;
    assign out_sof   = q.osof;
    assign out_eof   = q.oeof;
    assign err_short = q.err;

    // R6: a stalled output byte must not change.
    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sof) && $stable(out_eof)));

    // R1: a start marker only on the first byte of a frame.
    a_r1_sof_first: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> (q.cnt == CW'(1)));

    // R2: no frame ends below the minimum length.
    a_r2_eof_len: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |-> (q.cnt >= MIN_C));

    // R3: the first tag byte leaves right after the address fields.
    a_r3_tag_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TAG && q.tidx == '0 && out_valid) |-> (q.cnt == ADDR_C));

    // R7: the short-frame error is a single-cycle pulse.
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_short |=> !err_short);

endmodule

// File: rtl/tx_tag_pad.sv
module tx_tag_pad #(
    parameter int TAG_BYTES = 4,
    parameter int ADDR_LEN  = 12,
    parameter int MIN_LEN   = 60
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_tag_all,
    input  logic [8*TAG_BYTES-1:0] cfg_tag,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [7:0]             in_data,
    input  logic                   in_sof,
    input  logic                   in_eof,
    input  logic                   in_tag_req,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [7:0]             out_data,
    output logic                   out_sof,
    output logic                   out_eof,
    output logic                   err_short
);

    localparam int IW = (TAG_BYTES > 1) ? $clog2(TAG_BYTES) : 1;

    logic [IW-1:0] tag_idx;
    logic [7:0]    tag_byte;

    tx_tag_pad_tagsel #(
        .TAG_BYTES (TAG_BYTES)
    ) u_tagsel (
        .tag_word (cfg_tag),
        .idx      (tag_idx),
        .tag_byte (tag_byte)
    );

    tx_tag_pad_ctrl #(
        .TAG_BYTES (TAG_BYTES),
        .ADDR_LEN  (ADDR_LEN),
        .MIN_LEN   (MIN_LEN)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_tag_all (cfg_tag_all),
        .tag_byte    (tag_byte),
        .tag_idx     (tag_idx),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .in_sof      (in_sof),
        .in_eof      (in_eof),
        .in_tag_req  (in_tag_req),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_sof     (out_sof),
        .out_eof     (out_eof),
        .err_short   (err_short)
    );

endmodule

// File: tb/tx_tag_pad_bench.sv
module tx_tag_pad_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TAGB = 4;
    localparam int ADDR = 12;
    localparam int MINL = 60;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_tag_all;
    logic [31:0] cfg_tag;
    logic        in_valid, in_ready, in_sof, in_eof, in_tag_req;
    logic [7:0]  in_data;
    logic        out_valid, out_ready, out_sof, out_eof, err_short;
    logic [7:0]  out_data;

    tx_tag_pad u_tx_tag_pad (
        .clk(clk), .rst_n(rst_n), .cfg_tag_all(cfg_tag_all), .cfg_tag(cfg_tag),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_tag_req(in_tag_req),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .err_short(err_short)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_err, seen_err, stall_cnt;
    logic [10:0] in_q[$];   // {sof, eof, req, data}
    logic [11:0] exp_q[$];  // {kind, sof, eof, data}; kind 0 data, 1 tag, 2 pad

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic string kind_req(input logic [1:0] k);
        if (k == 2'd1) return "R3";
        if (k == 2'd2) return "R2";
        return "R1";
    endfunction

    // Builds the input frame and its expected output from the requirements.
    task automatic add_frame(input int len, input bit req);
        logic [7:0] b[$];
        logic [9:0] e[$];
        bit ins;
        ins = cfg_tag_all | req;
        for (int i = 0; i < len; i++) b.push_back(8'($urandom));
        for (int i = 0; i < len; i++)
            in_q.push_back({1'(i == 0), 1'(i == len - 1), req, b[i]});
        if (ins && len < ADDR) exp_err++;              // R7
        for (int i = 0; i < len; i++) begin
            e.push_back({2'd0, b[i]});
            if (ins && len >= ADDR && i == ADDR - 1)    // R3, R9
                for (int k = 0; k < TAGB; k++)
                    e.push_back({2'd1, cfg_tag[8*(TAGB-1-k) +: 8]});
        end
        while (e.size() < MINL) e.push_back({2'd2, 8'h00}); // R2, R4
        for (int k = 0; k < e.size(); k++)
            exp_q.push_back({e[k][9:8], 1'(k == 0), 1'(k == e.size() - 1), e[k][7:0]});
    endtask

    task automatic run(input int pv, input int pr, input int limit);
        bit hold = 1'b0;
        logic [11:0] ex;
        seen_err = 0;
        for (int cyc = 0; ; cyc++) begin
            @(negedge clk);
            if (!hold) begin
                if (in_q.size() > 0 && $urandom_range(99) < pv) begin
                    in_valid = 1'b1;
                    {in_sof, in_eof, in_tag_req, in_data} = in_q[0];
                end else begin
                    in_valid = 1'b0;
                end
            end
            out_ready = ($urandom_range(99) < pr);
            #1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "extra output byte", int'(out_data), 0);
                end else begin
                    ex = exp_q.pop_front();
                    check(out_data == ex[7:0] && out_sof == ex[9] && out_eof == ex[8],
                          kind_req(ex[11:10]), "byte/markers",
                          int'({out_sof, out_eof, out_data}), int'(ex[9:0]));
                end
            end
            if (in_valid && !in_ready) stall_cnt++;
            hold = in_valid && !in_ready;
            if (in_valid && in_ready) void'(in_q.pop_front());
            if (err_short) seen_err++;
            if (in_q.size() == 0 && exp_q.size() == 0 && !hold && (!out_valid || out_ready))
                break;
            if (cyc > limit) begin
                check(1'b0, "R6", "run timeout, bytes left", exp_q.size(), 0);
                in_q.delete();
                exp_q.delete();
                break;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        if (err_short) seen_err++;
        check(seen_err == exp_err, "R7", "error pulse count", seen_err, exp_err);
        check(!out_valid, "R6", "output idle after drain", int'(out_valid), 0);
        exp_err = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_sof = 1'b0; in_eof = 1'b0; in_tag_req = 1'b0; in_data = 8'h00;
        cfg_tag_all = 1'b0; cfg_tag = 32'hA1B2C3D4;
        exp_err = 0; stall_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state
        check(!out_valid, "R8", "out_valid after reset", int'(out_valid), 0);
        check(!err_short, "R8", "err after reset", int'(err_short), 0);
        check(in_ready, "R8", "in_ready after reset", int'(in_ready), 1);

        // Directed lengths around the pad and tag boundaries (R1 R2 R4 R7 R9).
        add_frame(20, 0); add_frame(70, 0); add_frame(60, 0); add_frame(59, 0);
        add_frame(61, 0); add_frame(56, 1); add_frame(55, 1); add_frame(12, 1);
        add_frame(11, 1); add_frame(13, 1); add_frame(1, 0);  add_frame(1, 1);
        run(100, 100, 5000);

        // Same set under heavy backpressure (R6).
        add_frame(56, 1); add_frame(12, 1); add_frame(11, 1); add_frame(64, 0);
        run(60, 35, 8000);

        // R5: exact stall count for one long tagged frame.
        stall_cnt = 0;
        add_frame(70, 1);
        run(100, 100, 2000);
        check(stall_cnt == TAGB, "R5", "input stall cycles", stall_cnt, TAGB);

        // R4: global enable inserts without the per-frame bit.
        cfg_tag_all = 1'b1; cfg_tag = 32'h8100_0ABC;
        add_frame(30, 0); add_frame(5, 0); add_frame(57, 0);
        run(70, 60, 5000);

        // Random batches.
        for (int bt = 0; bt < 8; bt++) begin
            cfg_tag_all = bt[0];
            cfg_tag = $urandom;
            for (int f = 0; f < 12; f++)
                add_frame(int'($urandom_range(90, 1)), 1'($urandom_range(1)));
            run(int'($urandom_range(100, 40)), int'($urandom_range(100, 30)), 20000);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule